// File: doc/BRIEF.md
# A20 Gate Command Port Emulator

This block is a slow peripheral on a byte-wide I/O bus. It owns an 8-bit output-port register. Bit 1 of that register drives the A20 address-line enable. To change the register, the host writes the "load output port" command byte to the command address. It then writes the new register value to the data address. A20 therefore follows the data byte: 0xDF turns it on and 0xDD turns it off.

The block models a slow controller. Every write it accepts raises a busy flag in the status byte, and the flag stays up for a programmable number of clock cycles. The host is expected to poll the flag before each write. A write that arrives while the flag is up is dropped, and a sticky overrun flag records it. A read returns the status byte from the command address and the output-port register from the data address.

Top module: `a20_kbc_gate`

## Requirements
- R1: While reset is high and in the first cycle after it, `a20_en` is 0, `status` is 0x00 and `io_rdata` is 0x00. The output-port register starts at 0x00.
- R2: A write to the command address (0x64) or to the data address (0x60) is accepted when the busy bit is clear. The busy bit (`status` bit 1, mask 0x02) then reads 1 for exactly BUSY_CYCLES clock cycles, counted from the clock edge that accepts the write, and then reads 0.
- R3: The command byte 0xD1 followed by an accepted data write loads the data byte into the output-port register. A data byte of 0xDF makes `a20_en` 1 from the cycle after the data write.
- R4: A loaded data byte of 0xDD makes `a20_en` 0.
- R5: An accepted data write loads the register only when the last accepted command was 0xD1 and no accepted data write has come since that command. In every other case the register does not change: with no command at all, after a different command, or for a second data write.
- R6: A write to 0x60 or 0x64 that arrives while the busy bit is set is ignored. It does not change the register, does not disarm a pending 0xD1 and does not restart the busy window. It sets the overrun bit (`status` bit 5, mask 0x20), and that bit stays set until reset.
- R7: A read strobe places a value on `io_rdata` on the next cycle: the status byte for address 0x64, the output-port register for address 0x60, and 0x00 for any other address. A read in the same cycle as a write returns the value from before that write. Status bits other than 1 and 5 read 0.
- R8: A write to any address other than 0x60 or 0x64 has no effect. It sets neither busy nor overrun and does not arm a load.
- R9: `a20_en` always equals bit 1 of the output-port register. A loaded 0x02 gives 1 and a loaded 0xFD gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | ADDR_W | Port address |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| status | output | 8 | Status byte (bit 1 busy, bit 5 overrun) |
| a20_en | output | 1 | A20 enable, bit 1 of the output-port register |

## Verification
Two functions can land on the same clock edge: a write arriving, and the busy window closing. The bench issues a data write on the last edge at which busy is still set. That write must be dropped and must set overrun without restarting the window. An identical write one edge later must be accepted, and it must still find the 0xD1 arming in place. A read and a write are also strobed together on the command address, and the read must return the status byte from before the write while busy rises.

// File: rtl/a20_kbc_pkg.sv
package a20_kbc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_LOAD_OUT = 8'hD1;
  localparam int ST_BUSY_BIT = 1;
  localparam int ST_OVR_BIT  = 5;
  localparam int A20_BIT     = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_t;
endpackage

// File: rtl/a20_busy_timer.sv
module a20_busy_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      remain_q <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (remain_q == '0) busy <= 1'b0;
      else remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/a20_outport.sv
module a20_outport
  import a20_kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] port_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q  <= '0;
      armed_q <= 1'b0;
    end else if (cmd_wr) begin
      armed_q <= (wdata == CMD_LOAD_OUT);
    end else if (data_wr) begin
      if (armed_q) port_q <= wdata;
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/a20_kbc_gate.sv
module a20_kbc_gate
  import a20_kbc_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(8'h64),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(8'h60),
  parameter int              BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic [BYTE_W-1:0] status,
  output logic              a20_en
);
  port_sel_t         sel;
  logic              busy;
  logic              ovr_q;
  logic              accept;
  logic [BYTE_W-1:0] port_q;

  always_comb begin
    if (io_addr == CMD_ADDR)       sel = SEL_CMD;
    else if (io_addr == DATA_ADDR) sel = SEL_DATA;
    else                           sel = SEL_NONE;
  end

  assign accept = io_wr && (sel != SEL_NONE) && !busy;

  a20_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (busy)
  );

  a20_outport u_port (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (accept && (sel == SEL_CMD)),
    .data_wr (accept && (sel == SEL_DATA)),
    .wdata   (io_wdata),
    .port_q  (port_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ovr_q <= 1'b0;
    else if (io_wr && (sel != SEL_NONE) && busy) ovr_q <= 1'b1;
  end

  always_comb begin
    status              = '0;
    status[ST_BUSY_BIT] = busy;
    status[ST_OVR_BIT]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_rd) begin
      case (sel)
        SEL_CMD:  io_rdata <= status;
        SEL_DATA: io_rdata <= port_q;
        default:  io_rdata <= '0;
      endcase
    end
  end

  assign a20_en = port_q[A20_BIT];
endmodule

// File: rtl/a20_kbc_gate_chk.sv
module a20_kbc_gate_chk #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = ADDR_W'(8'h64),
  parameter logic [ADDR_W-1:0] DATA_ADDR   = ADDR_W'(8'h60),
  parameter int                BUSY_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        status,
  input logic              a20_en
);
  localparam int RW = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RW-1:0] run_q;
  logic          known;

  assign known = (io_addr == CMD_ADDR) || (io_addr == DATA_ADDR);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (status[1]) begin
      if (run_q != '1) run_q <= run_q + 1'b1;
    end else run_q <= '0;
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && known && !status[1]) |=> status[1]);

  // R2
  busy_window_max_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(BUSY_CYCLES));

  // R2
  busy_window_exact_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[1]) && !$past(rst)) |-> (run_q == RW'(BUSY_CYCLES)));

  // R6
  busy_write_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && known && status[1]) |=> status[5]);

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status[5] |=> status[5]);

  // R6
  busy_write_no_a20_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && status[1]) |=> $stable(a20_en));

  // R5
  a20_only_on_data_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && (io_addr == DATA_ADDR)) |=> $stable(a20_en));

  // R8
  foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !known && !status[1]) |=> !status[1]);

  // R7
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status & 8'hDD) == 8'h00);
endmodule

bind a20_kbc_gate a20_kbc_gate_chk #(
  .ADDR_W      (ADDR_W),
  .CMD_ADDR    (CMD_ADDR),
  .DATA_ADDR   (DATA_ADDR),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .io_wr   (io_wr),
  .io_addr (io_addr),
  .status  (status),
  .a20_en  (a20_en)
);

// File: tb/a20_kbc_gate_test.sv
module a20_kbc_gate_test;
  localparam int N = 4;
  localparam logic [7:0] CA = 8'h64;
  localparam logic [7:0] DA = 8'h60;
  localparam logic [8:0] VEC [0:5] = '{
    {1'b1, 8'hDF}, {1'b0, 8'hDD}, {1'b1, 8'h02},
    {1'b0, 8'hFD}, {1'b1, 8'hFF}, {1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0;
  logic io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [7:0] status;
  logic a20_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  a20_kbc_gate #(.BUSY_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .status(status), .a20_en(a20_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (status[1]) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    wait_idle();
    bus_wr(a, d);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[1]) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 a20 during reset", a20_en, 0);
    chk("R1 status during reset", status, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 a20 after reset", a20_en, 0);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 rdata after reset", io_rdata, 8'h00);

    // R3 R4 R9: vector table, command 0xD1 then data
    for (int i = 0; i < 6; i++) begin
      host_wr(CA, 8'hD1);
      host_wr(DA, VEC[i][7:0]);
      chk("R3/R4/R9 a20 from vector", a20_en, VEC[i][8]);
      wait_idle();
      bus_rd(DA, v);
      chk("R9 readback of output port", v, VEC[i][7:0]);
    end

    // R2: busy window length for each port
    wait_idle();
    bus_wr(CA, 8'h20);
    busy_len(n);
    chk("R2 busy length after command write", n, N);
    bus_wr(DA, 8'h55);
    busy_len(n);
    chk("R2 busy length after data write", n, N);
    chk("R2 busy clear after window", status, 8'h00);

    // R5: loads only when armed
    host_wr(CA, 8'hD1);
    host_wr(DA, 8'hDF);
    chk("R3 a20 on after DF", a20_en, 1);
    host_wr(DA, 8'hDD);
    chk("R5 second data write ignored", a20_en, 1);
    host_wr(CA, 8'h20);
    host_wr(DA, 8'hDD);
    chk("R5 other command does not arm", a20_en, 1);
    host_wr(CA, 8'hD1);
    host_wr(CA, 8'hAA);
    host_wr(DA, 8'hDD);
    chk("R5 later command disarms", a20_en, 1);
    wait_idle();
    bus_rd(DA, v);
    chk("R5 register unchanged", v, 8'hDF);

    // R8: foreign address
    wait_idle();
    bus_wr(8'h61, 8'hD1);
    chk("R8 foreign write no busy or overrun", status, 8'h00);
    host_wr(DA, 8'hDD);
    chk("R8 foreign write does not arm", a20_en, 1);

    // R7: reads
    wait_idle();
    bus_rd(CA, v);
    chk("R7 status read idle", v, 8'h00);
    bus_rd(8'h55, v);
    chk("R7 foreign read is zero", v, 8'h00);
    io_addr = CA; io_wdata = 8'h20; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk("R7 read with write returns old status", io_rdata, 8'h00);
    chk("R2 busy raised by same-cycle write", status, 8'h02);
    bus_rd(CA, v);
    chk("R7 status read while busy", v, 8'h02);

    // R6: write straight after a write
    do_reset();
    bus_wr(CA, 8'hD1);
    bus_wr(DA, 8'hDF);
    chk("R6 busy write ignored a20", a20_en, 0);
    chk("R6 overrun set", status, 8'h22);
    busy_len(n);
    chk("R6 window not restarted", n, N - 1);
    bus_wr(DA, 8'hDF);
    chk("R6 arming kept across dropped write", a20_en, 1);
    wait_idle();
    chk("R6 overrun sticky", status, 8'h20);
    bus_rd(CA, v);
    chk("R6 overrun visible on read", v, 8'h20);

    // R6 R2: write on the last busy edge
    do_reset();
    bus_wr(CA, 8'hD1);
    repeat (N - 1) @(negedge clk);
    chk("R2 busy on last window cycle", status, 8'h02);
    bus_wr(DA, 8'hDF);
    chk("R6 last-edge write dropped", a20_en, 0);
    chk("R6 last-edge overrun, window closed", status, 8'h20);
    bus_wr(DA, 8'hDF);
    chk("R3 next-edge write accepted", a20_en, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule